// File: doc/BRIEF.md
# I2C Master Command and Receive Queue

This block sits between a host register bus and the bus engine of an I2C master. The host writes one shared command register. Each write queues either a byte to send or a request to read one byte. The engine drains these entries in order through a valid/ready handshake. Bytes that the engine receives are pushed into a second queue, and the host pops them by reading the same register.

The host can read how full each queue is and can program a threshold for each one. The threshold comparisons drive two level-sensitive interrupt lines: one asks for more commands, the other asks the host to collect received data. Misuse of either queue raises a one-cycle error event. Overfilling either queue, or reading when nothing has been received, counts as misuse. A transfer abort from the engine empties both queues. Clearing the enable register also empties both queues and keeps them empty.

Top module: `i2cm_xfer_queue`

## Requirements
- R1: A host write to offset 0x10 with bit 8 clear queues a send entry whose bits 7:0 carry wdata[7:0] and whose bit 8 is 0. The engine receives entries on `eng_tx_cmd` in the order they were written, one per cycle in which `eng_tx_valid` and `eng_tx_ready` are both high.
- R2: A host write to offset 0x10 with bit 8 set queues a read request. It appears on `eng_tx_cmd` as bit 8 = 1 with bits 7:0 = 0, whatever the low byte written.
- R3: During a host read of offset 0x10, `reg_rdata[7:0]` shows the oldest received byte, and that entry is removed at the clock edge.
- R4: Reads of offset 0x74 and offset 0x78 return the number of entries in the command queue and in the receive queue, from 0 to DEPTH.
- R5: `irq_tx_empty` is high while the block is enabled and the command queue level is at or below the threshold written at offset 0x3C.
- R6: `irq_rx_full` is high while the block is enabled and the receive queue level is strictly above the threshold written at offset 0x38.
- R7: A host write to offset 0x10 while the command queue holds DEPTH entries is discarded. `evt_tx_over` is then high for exactly the one cycle after that edge.
- R8: An engine push while the receive queue holds DEPTH entries is discarded. `evt_rx_over` is then high for exactly the one cycle after that edge.
- R9: A host read of offset 0x10 while the receive queue is empty returns 0 and leaves the level at 0. `evt_rx_under` is then high for the one cycle after that edge.
- R10: A cycle with `eng_abort` high leaves both queue levels at 0 after that edge.
- R11: Offset 0x6C bit 0 is the enable, which is 0 after reset. While it reads 0, both queues are held empty. Host writes to 0x10 are then dropped without an overflow event, and both interrupt lines are low.
- R12: After reset, both levels, both thresholds and the enable read 0, `eng_tx_valid` is low, and all interrupt and event outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (pops on the command offset) |
| reg_addr | input | 8 | Host byte offset |
| reg_wdata | input | 9 | Host write data |
| reg_rdata | output | 16 | Host read data, valid in the strobe cycle |
| eng_tx_valid | output | 1 | Command queue has an entry |
| eng_tx_cmd | output | 9 | Oldest command: bit 8 read request, bits 7:0 byte |
| eng_tx_ready | input | 1 | Engine takes the current command |
| eng_rx_valid | input | 1 | Engine pushes a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_abort | input | 1 | Transfer abort, empties both queues |
| irq_tx_empty | output | 1 | Command queue at or below its threshold |
| irq_rx_full | output | 1 | Receive queue above its threshold |
| evt_tx_over | output | 1 | One-cycle pulse: host write dropped, queue full |
| evt_rx_over | output | 1 | One-cycle pulse: engine push dropped, queue full |
| evt_rx_under | output | 1 | One-cycle pulse: read of empty receive queue |

## Verification
The bench fills the command queue to exactly DEPTH and adds one more write. A design that let the extra entry in, or overwrote the oldest one, would show a wrong level or a wrong order when the queue drains. Both threshold lines are moved across their switching points one step at a time. An off-by-one compare would assert a line at the wrong level. Read requests are written with a nonzero low byte, so a design that passed the byte through would give itself away. Aborting and disabling while both queues hold data must leave zero levels. A design that cleared only one queue, or that kept accepting writes while disabled, would show leftover entries.

// File: rtl/i2cm_q_pkg.sv
// Shared constants and the command entry type for the I2C master queue block.
package i2cm_q_pkg;
    localparam logic [7:0] OFS_DATA_CMD = 8'h10;
    localparam logic [7:0] OFS_RX_THR   = 8'h38;
    localparam logic [7:0] OFS_TX_THR   = 8'h3C;
    localparam logic [7:0] OFS_ENABLE   = 8'h6C;
    localparam logic [7:0] OFS_TX_LVL   = 8'h74;
    localparam logic [7:0] OFS_RX_LVL   = 8'h78;

    localparam int CMD_W  = 9;
    localparam int RD_W   = 16;

    typedef struct packed {
        logic       is_read;
        logic [7:0] payload;
    } q_cmd_t;
endpackage

// File: rtl/i2cm_q_fifo.sv
// Synchronous FIFO with a flush input.
// Assumes: push is ignored when full, pop is ignored when empty, and flush
// overrides both in the same cycle. Storage has no reset; only the pointers
// and the count are reset.
module i2cm_q_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp, wp_nx, rp_nx;
    logic          do_push, do_pop;

    assign full    = (level == CW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[rp];

    // Pointer advance: plain increment when DEPTH is a power of two, wrap otherwise.
    generate
        if ((1 << AW) == DEPTH) begin : g_pow2
            assign wp_nx = wp + 1'b1;
            assign rp_nx = rp + 1'b1;
        end else begin : g_wrap
            assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
        end
    endgenerate

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= wp_nx;
            if (do_pop)  rp <= rp_nx;
            level <= level + CW'(do_push) - CW'(do_pop);
        end
    end

    // Entry storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    // R4
    fifo_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));

    // R4
    fifo_push_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop && !flush) |=> level == $past(level) + 1'b1);
endmodule

// File: rtl/i2cm_q_csr.sv
// Host-side register decode: enable, the two thresholds, the command push
// strobe, the receive pop strobe and the read-data mux.
// Assumes: single-cycle strobes, and read data that is valid in the strobe cycle.
module i2cm_q_csr
    import i2cm_q_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int TW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [7:0]      reg_addr,
    input  logic [8:0]      reg_wdata,
    output logic [RD_W-1:0] reg_rdata,
    input  logic [CW-1:0]   tx_level,
    input  logic [CW-1:0]   rx_level,
    input  logic [7:0]      rx_head,
    input  logic            rx_empty,
    output logic            en,
    output logic [TW-1:0]   tx_thr,
    output logic [TW-1:0]   rx_thr,
    output logic            cmd_push,
    output q_cmd_t          cmd_word,
    output logic            rx_pop
);
    logic sel_dc;

    assign sel_dc   = (reg_addr == OFS_DATA_CMD);
    assign cmd_push = reg_wr && sel_dc;
    assign rx_pop   = reg_rd && sel_dc;

    // Build the queued entry: a read request carries a zero byte.
    always_comb begin
        cmd_word.is_read = reg_wdata[8];
        cmd_word.payload = reg_wdata[8] ? 8'h00 : reg_wdata[7:0];
    end

    // Control register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en     <= 1'b0;
            tx_thr <= '0;
            rx_thr <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                OFS_ENABLE: en     <= reg_wdata[0];
                OFS_TX_THR: tx_thr <= reg_wdata[TW-1:0];
                OFS_RX_THR: rx_thr <= reg_wdata[TW-1:0];
                default:    ;
            endcase
        end
    end

    // Read-data mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_DATA_CMD: reg_rdata = rx_empty ? '0 : RD_W'(rx_head);
            OFS_TX_LVL:   reg_rdata = RD_W'(tx_level);
            OFS_RX_LVL:   reg_rdata = RD_W'(rx_level);
            OFS_TX_THR:   reg_rdata = RD_W'(tx_thr);
            OFS_RX_THR:   reg_rdata = RD_W'(rx_thr);
            OFS_ENABLE:   reg_rdata = RD_W'(en);
            default:      reg_rdata = '0;
        endcase
    end

    // R9
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && rx_empty) |-> reg_rdata == '0);
endmodule

// File: rtl/i2cm_q_irq.sv
// Threshold compares for the two interrupt lines, and registered one-cycle
// error events.
// Assumes: the raw error conditions are single-cycle and are decided by the caller.
module i2cm_q_irq #(
    parameter int DEPTH = 8,
    localparam int TW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] tx_level,
    input  logic [CW-1:0] rx_level,
    input  logic [TW-1:0] tx_thr,
    input  logic [TW-1:0] rx_thr,
    input  logic          tx_over_raw,
    input  logic          rx_over_raw,
    input  logic          rx_under_raw,
    output logic          irq_tx_empty,
    output logic          irq_rx_full,
    output logic          evt_tx_over,
    output logic          evt_rx_over,
    output logic          evt_rx_under
);
    assign irq_tx_empty = en && (tx_level <= CW'(tx_thr));
    assign irq_rx_full  = en && (rx_level >  CW'(rx_thr));

    // Register the error conditions into one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_tx_over  <= 1'b0;
            evt_rx_over  <= 1'b0;
            evt_rx_under <= 1'b0;
        end else begin
            evt_tx_over  <= tx_over_raw;
            evt_rx_over  <= rx_over_raw;
            evt_rx_under <= rx_under_raw;
        end
    end

    // R5
    tx_irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx_empty |-> en);

    // R6
    rx_irq_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx_full |-> rx_level != '0);
endmodule

// File: rtl/i2cm_xfer_queue.sv
// Top level of the I2C master queue block: a command queue (host to engine),
// a receive queue (engine to host), register decode and interrupt/event logic.
// Assumes: the engine pops commands only while eng_tx_valid is high. An abort,
// or a cleared enable, empties both queues.
module i2cm_xfer_queue
    import i2cm_q_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int TW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [7:0]       reg_addr,
    input  logic [8:0]       reg_wdata,
    output logic [RD_W-1:0]  reg_rdata,
    output logic             eng_tx_valid,
    output logic [CMD_W-1:0] eng_tx_cmd,
    input  logic             eng_tx_ready,
    input  logic             eng_rx_valid,
    input  logic [7:0]       eng_rx_data,
    input  logic             eng_abort,
    output logic             irq_tx_empty,
    output logic             irq_rx_full,
    output logic             evt_tx_over,
    output logic             evt_rx_over,
    output logic             evt_rx_under
);
    logic          en, flush, cmd_push, rx_pop, host_push;
    q_cmd_t        cmd_word;
    logic [TW-1:0] tx_thr, rx_thr;
    logic [CW-1:0] tx_level, rx_level;
    logic          tx_full, tx_empty, rx_full, rx_empty;
    logic [CMD_W-1:0] tx_head;
    logic [7:0]    rx_head;

    assign flush        = eng_abort || !en;
    assign host_push    = cmd_push && en;
    assign eng_tx_valid = !tx_empty;
    assign eng_tx_cmd   = tx_head;

    i2cm_q_csr #(.DEPTH(DEPTH)) u_csr (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_level(tx_level), .rx_level(rx_level), .rx_head(rx_head),
        .rx_empty(rx_empty), .en(en), .tx_thr(tx_thr), .rx_thr(rx_thr),
        .cmd_push(cmd_push), .cmd_word(cmd_word), .rx_pop(rx_pop)
    );

    i2cm_q_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(host_push),
        .wdata(cmd_word), .pop(eng_tx_ready), .head(tx_head),
        .level(tx_level), .full(tx_full), .empty(tx_empty)
    );

    i2cm_q_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(eng_rx_valid),
        .wdata(eng_rx_data), .pop(rx_pop), .head(rx_head),
        .level(rx_level), .full(rx_full), .empty(rx_empty)
    );

    i2cm_q_irq #(.DEPTH(DEPTH)) u_irq (
        .clk(clk), .rst_n(rst_n), .en(en),
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_thr(tx_thr), .rx_thr(rx_thr),
        .tx_over_raw(host_push && tx_full && !flush),
        .rx_over_raw(eng_rx_valid && rx_full && !flush),
        .rx_under_raw(rx_pop && rx_empty),
        .irq_tx_empty(irq_tx_empty), .irq_rx_full(irq_rx_full),
        .evt_tx_over(evt_tx_over), .evt_rx_over(evt_rx_over),
        .evt_rx_under(evt_rx_under)
    );

    // R10
    abort_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_abort |=> (tx_level == '0 && rx_level == '0));

    // R11
    disabled_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (tx_level == '0 && rx_level == '0 && !evt_tx_over));

    // R7
    tx_drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_push && tx_full && !eng_tx_ready && !flush) |=>
            (tx_level == $past(tx_level) && evt_tx_over));

    // R8
    rx_drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_valid && rx_full && !rx_pop && !flush) |=>
            (rx_level == $past(rx_level) && evt_rx_over));
endmodule

// File: tb/i2cm_xfer_queue_test.sv
module i2cm_xfer_queue_test;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [8:0]  reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        eng_tx_valid;
    logic [8:0]  eng_tx_cmd;
    logic        eng_tx_ready = 1'b0, eng_rx_valid = 1'b0, eng_abort = 1'b0;
    logic [7:0]  eng_rx_data = '0;
    logic        irq_tx_empty, irq_rx_full, evt_tx_over, evt_rx_over, evt_rx_under;

    int total = 0;
    int bad = 0;
    logic [8:0] tx_q[$];
    logic [7:0] rx_q[$];
    bit exp_en = 0;

    always #4 clk = ~clk;

    i2cm_xfer_queue #(.DEPTH(DEPTH)) uut (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [8:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // Driver: queue a host command and record the expected engine-side entry.
    task automatic host_cmd(logic [8:0] d);
        if (exp_en && tx_q.size() < DEPTH)
            tx_q.push_back(d[8] ? 9'h100 : {1'b0, d[7:0]});
        wr(8'h10, d);
    endtask

    // Driver: engine delivers a received byte.
    task automatic eng_push(logic [7:0] b);
        if (exp_en && rx_q.size() < DEPTH) rx_q.push_back(b);
        @(negedge clk);
        eng_rx_valid = 1'b1; eng_rx_data = b;
        @(negedge clk);
        eng_rx_valid = 1'b0;
    endtask

    task automatic eng_take(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            eng_tx_ready = 1'b1;
            @(negedge clk);
            eng_tx_ready = 1'b0;
        end
    endtask

    // Host pops a byte and compares with the scoreboard (R3).
    task automatic host_pop();
        logic [15:0] d;
        logic [7:0]  e;
        e = (rx_q.size() > 0) ? rx_q.pop_front() : 8'h00;
        rd(8'h10, d);
        check("R3 rx byte", d, {8'h00, e});
    endtask

    task automatic check_levels(string req);
        logic [15:0] d;
        rd(8'h74, d); check({req, " tx level"}, d, tx_q.size());
        rd(8'h78, d); check({req, " rx level"}, d, rx_q.size());
    endtask

    // Monitor: compares each accepted engine entry against the scoreboard (R1, R2).
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (eng_tx_ready && eng_tx_valid) begin
                if (tx_q.size() == 0) check("R1 unexpected entry", eng_tx_cmd, 9'h1ff);
                else check("R1 R2 cmd order", eng_tx_cmd, tx_q.pop_front());
            end
        end
    end

    task automatic run();
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 tx_valid", eng_tx_valid, 0);
        check("R12 irqs", {irq_tx_empty, irq_rx_full}, 0);
        check("R12 events", {evt_tx_over, evt_rx_over, evt_rx_under}, 0);
        rd(8'h6C, d); check("R12 enable", d, 0);
        rd(8'h3C, d); check("R12 tx thr", d, 0);
        rd(8'h38, d); check("R12 rx thr", d, 0);
        check_levels("R12");

        // R11: writes while disabled are dropped silently
        host_cmd(9'h0A5);
        check("R11 no tx_over", evt_tx_over, 0);
        check_levels("R11 disabled");

        wr(8'h6C, 9'h001); exp_en = 1;
        check("R5 irq at level0 thr0", irq_tx_empty, 1);

        host_cmd(9'h0A5); host_cmd(9'h03C); host_cmd(9'h1FF); host_cmd(9'h100);
        check_levels("R4");
        check("R5 irq off above thr", irq_tx_empty, 0);
        wr(8'h3C, 9'd4); check("R5 irq at level==thr", irq_tx_empty, 1);
        wr(8'h3C, 9'd3); check("R5 irq off level>thr", irq_tx_empty, 0);
        eng_take(4);
        check_levels("R1 drained");

        // R7 overflow of the command queue
        for (int i = 0; i < DEPTH; i++) host_cmd(9'(8'h10 + i));
        check("R4 tx valid when full", eng_tx_valid, 1);
        host_cmd(9'h0EE);
        check("R7 tx_over pulse", evt_tx_over, 1);
        @(negedge clk);
        check("R7 tx_over one cycle", evt_tx_over, 0);
        check_levels("R7 full");
        eng_take(DEPTH);
        check("R1 empty after drain", eng_tx_valid, 0);

        // R6 receive threshold
        eng_push(8'h11);
        check("R6 rx irq level1 thr0", irq_rx_full, 1);
        wr(8'h38, 9'd2);
        check("R6 rx irq level1 thr2", irq_rx_full, 0);
        eng_push(8'h22); eng_push(8'h33);
        check("R6 rx irq level3 thr2", irq_rx_full, 1);
        host_pop();
        check("R6 rx irq level2 thr2", irq_rx_full, 0);

        // R8 overflow of the receive queue
        for (int i = rx_q.size(); i < DEPTH; i++) eng_push(8'(8'h40 + i));
        eng_push(8'hFE);
        check("R8 rx_over pulse", evt_rx_over, 1);
        @(negedge clk);
        check("R8 rx_over one cycle", evt_rx_over, 0);
        check_levels("R8 full");
        for (int i = 0; i < DEPTH; i++) host_pop();

        // R9 underflow
        rd(8'h10, d);
        check("R9 empty read value", d, 0);
        check("R9 rx_under pulse", evt_rx_under, 1);
        check_levels("R9");

        // R10 abort flushes both queues
        host_cmd(9'h001); host_cmd(9'h002); eng_push(8'h77); eng_push(8'h78);
        @(negedge clk); eng_abort = 1'b1;
        @(negedge clk); eng_abort = 1'b0;
        tx_q.delete(); rx_q.delete();
        check("R10 tx valid", eng_tx_valid, 0);
        check_levels("R10");

        // R11 disable flushes and silences interrupts
        host_cmd(9'h005); host_cmd(9'h006); eng_push(8'h99); eng_push(8'h9A); eng_push(8'h9B);
        wr(8'h6C, 9'h000); exp_en = 0;
        @(negedge clk);
        tx_q.delete(); rx_q.delete();
        check("R11 irqs low", {irq_tx_empty, irq_rx_full}, 0);
        check_levels("R11 flushed");
        host_cmd(9'h033);
        check("R11 no event", evt_tx_over, 0);
        check_levels("R11 still empty");
    endtask

    initial begin
        fork
            run();
            begin
                repeat (200000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule